// File: doc/BRIEF.md
# Calibrated Sensor Temperature and Bank Maximum

This block turns raw readings from on-die temperature sensors into signed temperatures in millidegrees Celsius and reports the hottest reading of each bank. A bank is a group of readings that arrive one at a time as (sensor index, raw code) pairs, and the pair carrying the end-of-bank flag closes the group. Each reading is scaled with a fixed calibration formula. The formula uses a gain-error constant, a slope correction, a calibration temperature, and an offset for each sensor. Readings that come out implausibly hot are forced to zero before they enter the maximum.

The scale factor comes from two chained integer divisions of a fixed numerator. A single sequential divider, shared by both divisions, produces it one quotient bit per cycle. While a reading is being converted, `in_ready` stays low. When the last reading of a bank has been folded in, the bank maximum appears on `out_max` together with a one-cycle `out_done` pulse. When the calibration-valid input is low, built-in default constants are used in place of the calibration inputs.

Top module: `thermo_bank_max`

## Requirements
- R1: Only bits 11:0 of `in_raw` take part in the conversion. Any value in the upper bits gives the same result as the same low 12 bits with the upper bits at zero.
- R2: The value q = ((203450520·8) / (165 + slope)) / (10000 + gain) is computed with truncating signed division. The temperature is degc·500 − ((q · (raw − offset[sensor] − 3350)) >>> 3). Everything wraps at signed 32 bits.
- R3: When `cal_valid` is 1, the formula uses `cal_gain_err` as gain, `cal_degc` as degc, and field i of `cal_offsets` (bits i·9 +: 9) as the offset of sensor i.
- R4: When `cal_valid` is 1, the slope is −`cal_slope_mag` if both `cal_slope_sign` and `cal_slope_id` are 1. In every other combination it is +`cal_slope_mag`.
- R5: When `cal_valid` is 0, the formula uses gain 512, slope 0, degc 40 and offset 260 for every sensor, whatever the other calibration inputs hold.
- R6: A converted temperature greater than 200000 is replaced by 0 before it enters the maximum, so `out_max` never exceeds 200000.
- R7: `out_max` is the largest clamped temperature among the readings from the first reading after the previous end-of-bank flag up to and including the flagged one. The running maximum starts at −2147483648, so a bank whose readings are all negative reports a negative maximum.
- R8: `in_ready` drops in the cycle after a reading is accepted and stays low while the divider runs. `out_done` is high for exactly one cycle per bank.
- R9: After reset, `in_ready` is 1, `out_done` is 0 and `out_max` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cal_valid | input | 1 | 1: use the calibration inputs; 0: use the defaults |
| cal_gain_err | input | GE_W (10) | Gain-error constant |
| cal_slope_mag | input | SLOPE_W (6) | Slope correction magnitude |
| cal_slope_sign | input | 1 | Slope sign flag |
| cal_slope_id | input | 1 | Slope qualifier flag; negation needs both flags |
| cal_degc | input | DEGC_W (6) | Calibration temperature in degrees |
| cal_offsets | input | NUM_SENS·OFS_W (45) | Per-sensor offsets, sensor i at bits i·OFS_W +: OFS_W |
| in_valid | input | 1 | Reading present |
| in_ready | output | 1 | Block can accept a reading |
| in_sensor | input | SEL_W (3) | Sensor index of the reading |
| in_raw | input | RAW_W (16) | Raw sensor code; bits 11:0 used |
| in_last | input | 1 | Reading closes the bank |
| out_max | output | 32 | Signed bank maximum in millidegrees |
| out_done | output | 1 | One-cycle pulse when `out_max` is updated |

## Verification
Two situations are hard to reach from the ports. The first is a bank where the clamp decides the result. The second is a bank whose readings are all below zero, so that the start value of the running maximum matters. The stimulus covers both. With default constants, a raw code of 0 converts to about 443 °C, which the block must replace with zero. Codes near 4095 convert well below zero, and banks made only of such codes show whether the true negative maximum comes through. The slope sign is exercised with every pairing of its two flags. The upper raw bits are set on a reading whose low bits are known.

// File: rtl/thermo_pkg.sv
package thermo_pkg;
  localparam int          DW          = 32;
  localparam int          RAW_BITS    = 12;
  localparam int          FRAC_BITS   = 3;
  localparam logic signed [DW-1:0] NUMER       = 32'sd1627604160;
  localparam logic signed [DW-1:0] SLOPE_BASE  = 32'sd165;
  localparam logic signed [DW-1:0] GAIN_BASE   = 32'sd10000;
  localparam logic signed [DW-1:0] CODE_BIAS   = 32'sd3350;
  localparam logic signed [DW-1:0] DEGC_SCALE  = 32'sd500;
  localparam logic signed [DW-1:0] BOGUS_LIMIT = 32'sd200000;
  localparam logic signed [DW-1:0] MOST_NEG    = 32'sh8000_0000;
  localparam logic signed [DW-1:0] DEF_GAIN    = 32'sd512;
  localparam logic signed [DW-1:0] DEF_OFS     = 32'sd260;
  localparam logic signed [DW-1:0] DEF_DEGC    = 32'sd40;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DIV_A,
    ST_DIV_B,
    ST_CONV
  } conv_state_t;
endpackage

// File: rtl/thermo_sdiv.sv
module thermo_sdiv #(
  parameter int W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic signed [W-1:0] num,
  input  logic signed [W-1:0] den,
  output logic                busy,
  output logic                done,
  output logic signed [W-1:0] quot
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  rem_q, quo_q, den_abs;
  logic [CW-1:0] cnt;
  logic          neg_q;
  logic [W:0]    trial;
  logic [W-1:0]  rem_nx, quo_nx;

  always_comb begin
    trial  = {rem_q, quo_q[W-1]} - {1'b0, den_abs};
    quo_nx = {quo_q[W-2:0], ~trial[W]};
    rem_nx = trial[W] ? {rem_q[W-2:0], quo_q[W-1]} : trial[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q   <= '0;
      quo_q   <= '0;
      den_abs <= '0;
      cnt     <= '0;
      neg_q   <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
      quot    <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem_q   <= '0;
        quo_q   <= num[W-1] ? W'(-num) : W'(num);
        den_abs <= den[W-1] ? W'(-den) : W'(den);
        neg_q   <= num[W-1] ^ den[W-1];
        cnt     <= '0;
        busy    <= 1'b1;
      end else if (busy) begin
        rem_q <= rem_nx;
        quo_q <= quo_nx;
        cnt   <= cnt + 1'b1;
        if (cnt == CW'(W - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
          quot <= neg_q ? -$signed(quo_nx) : $signed(quo_nx);
        end
      end
    end
  end

  // R2
  rem_bound_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (rem_q < den_abs));
endmodule

// File: rtl/thermo_cal_sel.sv
module thermo_cal_sel
  import thermo_pkg::*;
#(
  parameter int NUM_SENS = 5,
  parameter int OFS_W    = 9,
  parameter int GE_W     = 10,
  parameter int SLOPE_W  = 6,
  parameter int DEGC_W   = 6
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cal_valid,
  input  logic [GE_W-1:0]           cal_gain_err,
  input  logic [SLOPE_W-1:0]        cal_slope_mag,
  input  logic                      cal_slope_sign,
  input  logic                      cal_slope_id,
  input  logic [DEGC_W-1:0]         cal_degc,
  input  logic [NUM_SENS*OFS_W-1:0] cal_offsets,
  output logic signed [DW-1:0]      gain_err,
  output logic signed [DW-1:0]      slope,
  output logic signed [DW-1:0]      degc,
  output logic [NUM_SENS*DW-1:0]    ofs_flat
);
  logic signed [DW-1:0] mag_ext;
  assign mag_ext = $signed(DW'(cal_slope_mag));

  always_ff @(posedge clk) begin
    if (rst || !cal_valid) begin
      gain_err <= DEF_GAIN;
      slope    <= '0;
      degc     <= DEF_DEGC;
    end else begin
      gain_err <= $signed(DW'(cal_gain_err));
      slope    <= (cal_slope_sign && cal_slope_id) ? -mag_ext : mag_ext;
      degc     <= $signed(DW'(cal_degc));
    end
  end

  for (genvar i = 0; i < NUM_SENS; i++) begin : g_ofs
    always_ff @(posedge clk) begin
      if (rst || !cal_valid) ofs_flat[i*DW +: DW] <= DEF_OFS;
      else ofs_flat[i*DW +: DW] <= DW'(cal_offsets[i*OFS_W +: OFS_W]);
    end
  end

  // R4
  slope_neg_chk: assert property (@(posedge clk) disable iff (rst)
    (cal_valid && cal_slope_sign && cal_slope_id) |=> (slope <= 0));
  // R5
  default_cal_chk: assert property (@(posedge clk) disable iff (rst)
    !cal_valid |=> (gain_err == DEF_GAIN && slope == 0 && degc == DEF_DEGC));
endmodule

// File: rtl/thermo_max_acc.sv
module thermo_max_acc
  import thermo_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 smp_valid,
  input  logic                 smp_last,
  input  logic signed [DW-1:0] smp_temp,
  output logic signed [DW-1:0] out_max,
  output logic                 out_done
);
  logic signed [DW-1:0] run_max, clamped, new_max;

  always_comb begin
    clamped = (smp_temp > BOGUS_LIMIT) ? '0 : smp_temp;
    new_max = (clamped > run_max) ? clamped : run_max;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_max  <= MOST_NEG;
      out_max  <= '0;
      out_done <= 1'b0;
    end else begin
      out_done <= 1'b0;
      if (smp_valid) begin
        if (smp_last) begin
          out_max  <= new_max;
          out_done <= 1'b1;
          run_max  <= MOST_NEG;
        end else begin
          run_max <= new_max;
        end
      end
    end
  end

  // R6
  clamp_limit_chk: assert property (@(posedge clk) disable iff (rst)
    out_done |-> (out_max <= BOGUS_LIMIT));
  // R7
  max_grow_chk: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && !smp_last) |=> (run_max >= $past(run_max)));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    out_done |=> !out_done);
endmodule

// File: rtl/thermo_bank_max.sv
module thermo_bank_max
  import thermo_pkg::*;
#(
  parameter int NUM_SENS = 5,
  parameter int RAW_W    = 16,
  parameter int OFS_W    = 9,
  parameter int GE_W     = 10,
  parameter int SLOPE_W  = 6,
  parameter int DEGC_W   = 6,
  parameter int SEL_W    = (NUM_SENS > 1) ? $clog2(NUM_SENS) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cal_valid,
  input  logic [GE_W-1:0]           cal_gain_err,
  input  logic [SLOPE_W-1:0]        cal_slope_mag,
  input  logic                      cal_slope_sign,
  input  logic                      cal_slope_id,
  input  logic [DEGC_W-1:0]         cal_degc,
  input  logic [NUM_SENS*OFS_W-1:0] cal_offsets,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [SEL_W-1:0]          in_sensor,
  input  logic [RAW_W-1:0]          in_raw,
  input  logic                      in_last,
  output logic signed [31:0]        out_max,
  output logic                      out_done
);
  localparam int TAB_N = 1 << SEL_W;

  conv_state_t          state;
  logic [RAW_BITS-1:0]  raw_q;
  logic [SEL_W-1:0]     sel_q;
  logic                 last_q;
  logic signed [DW-1:0] q_b;
  logic signed [DW-1:0] gain_err, slope, degc;
  logic [NUM_SENS*DW-1:0] ofs_flat;
  logic signed [DW-1:0] ofs_tab [TAB_N];
  logic                 accept, div_start, div_busy, div_done;
  logic signed [DW-1:0] div_num, div_den, div_quot;
  logic signed [DW-1:0] diff, prod, scaled, temp;

  if (RAW_W > RAW_BITS) begin : g_hi
    logic unused_raw_hi;
    assign unused_raw_hi = ^in_raw[RAW_W-1:RAW_BITS];
  end

  thermo_cal_sel #(
    .NUM_SENS(NUM_SENS), .OFS_W(OFS_W), .GE_W(GE_W),
    .SLOPE_W(SLOPE_W), .DEGC_W(DEGC_W)
  ) u_cal (
    .clk(clk), .rst(rst), .cal_valid(cal_valid),
    .cal_gain_err(cal_gain_err), .cal_slope_mag(cal_slope_mag),
    .cal_slope_sign(cal_slope_sign), .cal_slope_id(cal_slope_id),
    .cal_degc(cal_degc), .cal_offsets(cal_offsets),
    .gain_err(gain_err), .slope(slope), .degc(degc), .ofs_flat(ofs_flat)
  );

  for (genvar i = 0; i < TAB_N; i++) begin : g_tab
    if (i < NUM_SENS) begin : g_real
      assign ofs_tab[i] = ofs_flat[i*DW +: DW];
    end else begin : g_pad
      assign ofs_tab[i] = DEF_OFS;
    end
  end

  assign in_ready  = (state == ST_IDLE);
  assign accept    = in_valid && in_ready;
  assign div_start = accept || (state == ST_DIV_A && div_done);
  assign div_num   = (state == ST_IDLE) ? NUMER : div_quot;
  assign div_den   = (state == ST_IDLE) ? (SLOPE_BASE + slope) : (GAIN_BASE + gain_err);

  thermo_sdiv #(.W(DW)) u_div (
    .clk(clk), .rst(rst), .start(div_start), .num(div_num), .den(div_den),
    .busy(div_busy), .done(div_done), .quot(div_quot)
  );

  always_comb begin
    diff   = $signed(DW'(raw_q)) - ofs_tab[sel_q] - CODE_BIAS;
    prod   = q_b * diff;
    scaled = prod >>> FRAC_BITS;
    temp   = degc * DEGC_SCALE - scaled;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      raw_q  <= '0;
      sel_q  <= '0;
      last_q <= 1'b0;
      q_b    <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          raw_q  <= in_raw[RAW_BITS-1:0];
          sel_q  <= in_sensor;
          last_q <= in_last;
          state  <= ST_DIV_A;
        end
        ST_DIV_A: if (div_done) state <= ST_DIV_B;
        ST_DIV_B: if (div_done) begin
          q_b   <= div_quot;
          state <= ST_CONV;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  thermo_max_acc u_acc (
    .clk(clk), .rst(rst),
    .smp_valid(state == ST_CONV), .smp_last(last_q), .smp_temp(temp),
    .out_max(out_max), .out_done(out_done)
  );

  // R8
  busy_blocks_input_chk: assert property (@(posedge clk) disable iff (rst)
    div_busy |-> !in_ready);
  // R8
  accept_drops_ready_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> !in_ready);
endmodule

// File: tb/sim_thermo_bank_max.sv
`timescale 1ns/1ps
module sim_thermo_bank_max;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cal_valid = 1'b0;
  logic [9:0]  cal_gain_err = '0;
  logic [5:0]  cal_slope_mag = '0;
  logic        cal_slope_sign = 1'b0;
  logic        cal_slope_id = 1'b0;
  logic [5:0]  cal_degc = '0;
  logic [44:0] cal_offsets = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_sensor = '0;
  logic [15:0] in_raw = '0;
  logic        in_last = 1'b0;
  logic signed [31:0] out_max;
  logic        out_done;

  int checks = 0;
  int fails  = 0;
  int exp_q[$];
  string tag_q[$];
  int m_ge, m_slope, m_degc;
  int m_ofs[5];
  int run_max;
  logic prev_done = 1'b0;

  always #2 clk = ~clk;

  thermo_bank_max u0 (
    .clk(clk), .rst(rst), .cal_valid(cal_valid), .cal_gain_err(cal_gain_err),
    .cal_slope_mag(cal_slope_mag), .cal_slope_sign(cal_slope_sign),
    .cal_slope_id(cal_slope_id), .cal_degc(cal_degc), .cal_offsets(cal_offsets),
    .in_valid(in_valid), .in_ready(in_ready), .in_sensor(in_sensor),
    .in_raw(in_raw), .in_last(in_last), .out_max(out_max), .out_done(out_done)
  );

  function automatic int model(int raw12, int ofs);
    int t;
    t = 1627604160;
    t = t / (165 + m_slope);
    t = t / (10000 + m_ge);
    t = t * (raw12 - ofs - 3350);
    t = t >>> 3;
    t = m_degc * 500 - t;
    if (t > 200000) t = 0;
    return t;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R3 R4 R5: the bench derives constants from the requirements
  task automatic set_cal(bit v, int ge, int mag, bit sgn, bit id, int dc,
                         int o0, int o1, int o2, int o3, int o4);
    cal_valid = v; cal_gain_err = 10'(ge); cal_slope_mag = 6'(mag);
    cal_slope_sign = sgn; cal_slope_id = id; cal_degc = 6'(dc);
    cal_offsets = {9'(o4), 9'(o3), 9'(o2), 9'(o1), 9'(o0)};
    if (v) begin
      m_ge = ge; m_degc = dc;
      m_slope = (sgn && id) ? -mag : mag;
      m_ofs[0] = o0; m_ofs[1] = o1; m_ofs[2] = o2; m_ofs[3] = o3; m_ofs[4] = o4;
    end else begin
      m_ge = 512; m_slope = 0; m_degc = 40;
      for (int i = 0; i < 5; i++) m_ofs[i] = 260;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic send(int idx, int raw16, bit last, string req);
    int t;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_sensor = 3'(idx); in_raw = 16'(raw16); in_last = last;
    t = model(raw16 & 12'hFFF, m_ofs[idx]);   // R1: low 12 bits only
    if (t > run_max) run_max = t;
    if (last) begin
      exp_q.push_back(run_max);
      tag_q.push_back(req);
      run_max = 32'sh8000_0000;
    end
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 ready low after accept", int'(in_ready), 0);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (out_done && prev_done) check("R8 done pulse width", 2, 1);
      if (out_done) begin
        if (exp_q.size() == 0) check("R7 unexpected result", out_max, 0);
        else check(tag_q.pop_front(), out_max, exp_q.pop_front());
      end
    end
    prev_done = out_done;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    run_max = 32'sh8000_0000;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check("R9 reset in_ready", int'(in_ready), 1);
    check("R9 reset out_done", int'(out_done), 0);
    check("R9 reset out_max", out_max, 0);

    // R5: defaults apply while cal_valid is low, junk on other inputs
    set_cal(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    cal_gain_err = 10'd999; cal_degc = 6'd7; cal_slope_mag = 6'd33;
    send(1, 3500, 0, "R2 R5 R7 default pair");
    send(2, 3610, 1, "R2 R5 R7 default pair");
    send(0, 3610, 1, "R2 R5 single 20000");
    drain();
    // R1: upper raw bits ignored
    send(3, 16'hF000 | 3500, 1, "R1 upper bits");
    drain();
    // R6: bogus hot reading clamps to zero
    send(0, 0, 0, "R6 clamp with cold");
    send(1, 4095, 1, "R6 clamp with cold");
    send(4, 0, 1, "R6 clamp alone");
    // R7: all negative bank, then restart
    send(2, 4095, 0, "R7 all negative");
    send(3, 4000, 1, "R7 all negative");
    send(0, 3400, 0, "R7 hot bank");
    send(1, 3300, 1, "R7 hot bank");
    send(4, 4050, 1, "R7 restart after bank");
    drain();
    // R3 R4: calibrated, negated slope
    set_cal(1, 300, 10, 1, 1, 30, 250, 270, 240, 280, 300);
    send(0, 3600, 0, "R3 R4 negated slope");
    send(3, 3450, 0, "R3 R4 negated slope");
    send(4, 3900, 1, "R3 R4 negated slope");
    drain();
    set_cal(1, 300, 10, 1, 0, 30, 250, 270, 240, 280, 300);
    send(1, 3500, 1, "R4 sign only positive");
    drain();
    set_cal(1, 700, 20, 0, 1, 55, 100, 511, 0, 200, 300);
    send(1, 3700, 0, "R3 R4 id only positive");
    send(2, 3000, 1, "R3 R4 id only positive");
    drain();
    set_cal(1, 1023, 63, 1, 1, 63, 0, 0, 0, 0, 0);
    send(2, 3800, 1, "R3 R4 extreme cal");
    drain();
    check("R7 all results seen", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule